// File: doc/BRIEF.md
# Filtered Received-Message Logger

This block records messages arriving from a set of readout channels into a 4096-word RAM. Each message is stored as a fixed record of four 16-bit words. The record holds a request identifier, a 24-bit orbit number, a 12-bit bunch-crossing number, the sender identifier and the number of the channel the message came in on. Records are laid down one after another. A write pointer shows where the next record will go, and it wraps back to address 0 when the RAM is full.

A channel filter decides which messages are kept. Its low byte is a match pattern and its high byte is a per-bit enable. A message is kept only if its channel number agrees with the pattern on every enabled bit. Each channel has a one-entry holding slot. When several channels deliver in the same cycle, the lowest-numbered full slot is written first, one record per cycle. The channel number of each input is its index in the input vectors.

A register bus can read and write every word of the RAM. Reads return data one cycle after the address is presented. The bus also reads and writes the filter register and reads the pointer.

Top module: `msg_logger`

## Requirements
- R1: A record is four words. Word 0 = {4'b0000, request[3:0], orbit[23:16]}. Word 1 = orbit[15:0]. Word 2 = {4'b0000, bunch[11:0]}. Word 3 = {sender[7:0], channel[7:0]}, where channel is the input index.
- R2: A record is written at word addresses wr_ptr+0 to wr_ptr+3. A message sampled at clock edge t from a channel whose slot is free is written at edge t+1, as long as no lower-numbered slot is full.
- R3: wr_ptr is 0 after reset. It grows by exactly 4 for each record written and does not change in any cycle without a record write.
- R4: After the last record slot (base 4092) is filled, wr_ptr wraps to 0 and the next record is written at address 0.
- R5: The filter register resets to 0x0000. A write on the filter port appears on filt_q after the next clock edge.
- R6: Let bits 7:0 of the filter be the pattern and bits 15:8 be the enable. A message is stored only if ((channel XOR pattern) AND enable) == 0. A filtered message has no effect on wr_ptr. With enable == 0, every message is stored.
- R7: Messages that arrive in the same cycle are written one per cycle in ascending channel order. Each waits in its channel's holding slot until it is written.
- R8: A message is dropped if it arrives on a channel whose slot is still full and is not being written in that cycle. The message already held is kept unchanged.
- R9: mem_rdata shows the RAM word at mem_addr one cycle after the address is presented, and is 0 after reset. A bus write with mem_we stores mem_wdata at mem_addr.
- R10: If a bus write and a record write hit the same address in the same cycle, the record write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_valid | input | NUM_CH | One message strobe per channel |
| msg_req | input | NUM_CH*4 | Request identifiers, channel c in bits [4c+3:4c] |
| msg_orbit | input | NUM_CH*24 | Orbit numbers, per channel |
| msg_bunch | input | NUM_CH*12 | Bunch-crossing numbers, per channel |
| msg_sender | input | NUM_CH*8 | Sender identifiers, per channel |
| cfg_filt_we | input | 1 | Filter register write strobe |
| cfg_filt_wdata | input | 16 | Filter value: enable in [15:8], pattern in [7:0] |
| filt_q | output | 16 | Current filter value |
| mem_addr | input | ADDR_W | Bus word address into the RAM |
| mem_we | input | 1 | Bus write strobe |
| mem_wdata | input | 16 | Bus write data |
| mem_rdata | output | 16 | Bus read data, one cycle after mem_addr |
| wr_ptr | output | ADDR_W | Word address of the next record |

## Verification
The bench walks a table of filter settings against different channel numbers. It includes a case where the pattern is set but no bit is enabled, which must store the message. A design that inverted the mask, or ignored the enable byte, would store or skip the wrong records and move the pointer in the wrong cycles.

All four channels are fired in the same cycle. The bench then checks the pointer after every edge and the channel byte of each record. This catches a design with the wrong priority, or one that writes two records per cycle and loses one.

A second message is sent to a channel whose slot is still occupied. This catches a design that overwrites the held message. A bus write is made to an address that a record write hits in the same cycle; a design with the wrong port priority leaves the bus data in place. The bench also fills the RAM to check the wrap, which catches a pointer that stalls at the top or starts again at a nonzero base.

// File: rtl/msg_logger_pkg.sv
package msg_logger_pkg;

   localparam int WORD_W   = 16;
   localparam int REQ_W    = 4;
   localparam int ORBIT_W  = 24;
   localparam int BUNCH_W  = 12;
   localparam int SENDER_W = 8;
   localparam int CHN_W    = 8;
   localparam int FILT_W   = 2 * CHN_W;
   localparam int REC_WORDS = 4;

   typedef struct packed {
      logic [REQ_W-1:0]    req;
      logic [ORBIT_W-1:0]  orbit;
      logic [BUNCH_W-1:0]  bunch;
      logic [SENDER_W-1:0] sender;
   } msg_t;

   // Builds word k of a record (k = low two address bits).
   function automatic logic [WORD_W-1:0] rec_word(msg_t m, logic [CHN_W-1:0] ch, int unsigned k);
      logic [WORD_W-1:0] w;
      case (k)
         0:       w = {4'b0000, m.req, m.orbit[23:16]};
         1:       w = m.orbit[15:0];
         2:       w = {4'b0000, m.bunch};
         default: w = {m.sender, ch};
      endcase
      return w;
   endfunction

endpackage

// File: rtl/msg_chan_slot.sv
module msg_chan_slot
   import msg_logger_pkg::*;
#(
   parameter int CH_IDX = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  msg_t             in_msg,
   input  logic [CHN_W-1:0] pat,
   input  logic [CHN_W-1:0] en,
   input  logic             grant,
   output logic             full,
   output msg_t             held
);

   localparam logic [CHN_W-1:0] MY_CH = CHN_W'(CH_IDX);

   logic pass;
   logic accept;

   assign pass   = (((MY_CH ^ pat) & en) == '0);
   assign accept = in_valid && pass && (!full || grant);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         held <= '0;
      end else if (accept) begin
         full <= 1'b1;
         held <= in_msg;
      end else if (grant) begin
         full <= 1'b0;
      end
   end

   // R7
   grant_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> full);

   // R8
   busy_slot_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full && !grant |=> full && $stable(held));

   // R6
   filtered_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !full && in_valid && (((MY_CH ^ pat) & en) != '0) |=> !full);

endmodule

// File: rtl/msg_pick_lowest.sv
module msg_pick_lowest #(
   parameter int N  = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic          any,
   output logic [IW-1:0] idx
);

   logic [N:0] blocked;

   assign blocked[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]     = req[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | req[i];
   end

   assign any = blocked[N];

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = IW'(i);
      end
   end

   // R7
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R7
   no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> (grant != '0));

endmodule

// File: rtl/msg_record_ram.sv
module msg_record_ram
   import msg_logger_pkg::*;
#(
   parameter int ADDR_W = 12,
   localparam int ROW_W = ADDR_W - 2,
   localparam int ROWS  = 1 << ROW_W
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              log_we,
   input  logic [ROW_W-1:0]                  log_row,
   input  logic [REC_WORDS-1:0][WORD_W-1:0]  log_words,
   input  logic [ADDR_W-1:0]                 bus_addr,
   input  logic                              bus_we,
   input  logic [WORD_W-1:0]                 bus_wdata,
   output logic [WORD_W-1:0]                 bus_rdata
);

   logic [ROW_W-1:0]                 bus_row;
   logic [REC_WORDS-1:0][WORD_W-1:0] rd_q;
   logic [1:0]                       sel_q;

   assign bus_row = bus_addr[ADDR_W-1:2];

   for (genvar b = 0; b < REC_WORDS; b++) begin : g_bank
      logic [WORD_W-1:0] mem [ROWS];

      // Record write is placed last so it wins a same-address collision.
      always_ff @(posedge clk) begin
         if (bus_we && (bus_addr[1:0] == 2'(b))) mem[bus_row] <= bus_wdata;
         if (log_we) mem[log_row] <= log_words[b];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_q[b] <= '0;
         else        rd_q[b] <= mem[bus_row];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= '0;
      else        sel_q <= bus_addr[1:0];
   end

   assign bus_rdata = rd_q[sel_q];

endmodule

// File: rtl/msg_logger.sv
module msg_logger
   import msg_logger_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        msg_valid,
   input  logic [NUM_CH*REQ_W-1:0]    msg_req,
   input  logic [NUM_CH*ORBIT_W-1:0]  msg_orbit,
   input  logic [NUM_CH*BUNCH_W-1:0]  msg_bunch,
   input  logic [NUM_CH*SENDER_W-1:0] msg_sender,
   input  logic                     cfg_filt_we,
   input  logic [FILT_W-1:0]        cfg_filt_wdata,
   output logic [FILT_W-1:0]        filt_q,
   input  logic [ADDR_W-1:0]        mem_addr,
   input  logic                     mem_we,
   input  logic [WORD_W-1:0]        mem_wdata,
   output logic [WORD_W-1:0]        mem_rdata,
   output logic [ADDR_W-1:0]        wr_ptr
);

   localparam int ROW_W = ADDR_W - 2;
   localparam int IW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 1 || NUM_CH > (1 << CHN_W)) begin : g_bad_ch
      $error("msg_logger: NUM_CH out of range");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("msg_logger: ADDR_W too small for four-word records");
   end

   logic [NUM_CH-1:0] slot_full;
   logic [NUM_CH-1:0] slot_grant;
   msg_t              slot_msg [NUM_CH];
   logic              wr_any;
   logic [IW-1:0]     wr_idx;
   msg_t              wr_msg;
   logic [CHN_W-1:0]  wr_ch;
   logic [ROW_W-1:0]  row_q;
   logic [REC_WORDS-1:0][WORD_W-1:0] rec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           filt_q <= '0;
      else if (cfg_filt_we) filt_q <= cfg_filt_wdata;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
      msg_t in_m;
      assign in_m.req    = msg_req[c*REQ_W +: REQ_W];
      assign in_m.orbit  = msg_orbit[c*ORBIT_W +: ORBIT_W];
      assign in_m.bunch  = msg_bunch[c*BUNCH_W +: BUNCH_W];
      assign in_m.sender = msg_sender[c*SENDER_W +: SENDER_W];

      msg_chan_slot #(.CH_IDX(c)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (msg_valid[c]),
         .in_msg   (in_m),
         .pat      (filt_q[CHN_W-1:0]),
         .en       (filt_q[FILT_W-1:CHN_W]),
         .grant    (slot_grant[c]),
         .full     (slot_full[c]),
         .held     (slot_msg[c])
      );
   end

   msg_pick_lowest #(.N(NUM_CH)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (slot_full),
      .grant (slot_grant),
      .any   (wr_any),
      .idx   (wr_idx)
   );

   assign wr_msg = slot_msg[wr_idx];
   assign wr_ch  = CHN_W'(wr_idx);

   for (genvar k = 0; k < REC_WORDS; k++) begin : g_pack
      assign rec[k] = rec_word(wr_msg, wr_ch, k);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_q <= '0;
      else if (wr_any) row_q <= row_q + 1'b1;
   end

   assign wr_ptr = {row_q, 2'b00};

   msg_record_ram #(.ADDR_W(ADDR_W)) u_ram (
      .clk       (clk),
      .rst_n     (rst_n),
      .log_we    (wr_any),
      .log_row   (row_q),
      .log_words (rec),
      .bus_addr  (mem_addr),
      .bus_we    (mem_we),
      .bus_wdata (mem_wdata),
      .bus_rdata (mem_rdata)
   );

   // R3
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_any |=> wr_ptr == $past(wr_ptr) + ADDR_W'(4));

   // R3
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_any |=> $stable(wr_ptr));

   // R5
   filt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_filt_we |=> filt_q == $past(cfg_filt_wdata));

endmodule

// File: tb/msg_logger_bench.sv
module msg_logger_bench;

   localparam int CLK_P  = 10;
   localparam int NCH    = 4;
   localparam int AW     = 12;
   localparam int NVEC   = 8;

   // ch(2) req(4) orbit(24) bunch(12) sender(8) filter(16) expect_store(1)
   localparam logic [66:0] VEC [NVEC] = '{
      {2'd0, 4'hA, 24'h123456, 12'hABC, 8'h5A, 16'h0000, 1'b1},
      {2'd3, 4'h1, 24'hFEDCBA, 12'h001, 8'h11, 16'h0303, 1'b1},
      {2'd2, 4'h2, 24'h0000FF, 12'h7FF, 8'h22, 16'h0303, 1'b0},
      {2'd1, 4'h3, 24'hA5A5A5, 12'h555, 8'h33, 16'h0201, 1'b1},
      {2'd2, 4'h4, 24'h5A5A5A, 12'hAAA, 8'h44, 16'h0201, 1'b0},
      {2'd0, 4'hF, 24'hFFFFFF, 12'hFFF, 8'hFF, 16'h8000, 1'b1},
      {2'd1, 4'h6, 24'h010203, 12'h0C0, 8'h66, 16'h8080, 1'b0},
      {2'd3, 4'h7, 24'h800001, 12'h800, 8'h77, 16'h00FF, 1'b1}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NCH-1:0]  msg_valid = '0;
   logic [NCH*4-1:0]  msg_req = '0;
   logic [NCH*24-1:0] msg_orbit = '0;
   logic [NCH*12-1:0] msg_bunch = '0;
   logic [NCH*8-1:0]  msg_sender = '0;
   logic            cfg_filt_we = 1'b0;
   logic [15:0]     cfg_filt_wdata = '0;
   logic [15:0]     filt_q;
   logic [AW-1:0]   mem_addr = '0;
   logic            mem_we = 1'b0;
   logic [15:0]     mem_wdata = '0;
   logic [15:0]     mem_rdata;
   logic [AW-1:0]   wr_ptr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   msg_logger #(.NUM_CH(NCH), .ADDR_W(AW)) u_msg_logger (
      .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_req(msg_req),
      .msg_orbit(msg_orbit), .msg_bunch(msg_bunch), .msg_sender(msg_sender),
      .cfg_filt_we(cfg_filt_we), .cfg_filt_wdata(cfg_filt_wdata), .filt_q(filt_q),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .wr_ptr(wr_ptr)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic load_fields(int ch, logic [3:0] rq, logic [23:0] orb, logic [11:0] bn, logic [7:0] sd);
      msg_req[ch*4 +: 4]    = rq;
      msg_orbit[ch*24 +: 24] = orb;
      msg_bunch[ch*12 +: 12] = bn;
      msg_sender[ch*8 +: 8]  = sd;
   endtask

   task automatic set_filter(logic [15:0] f);
      @(negedge clk);
      cfg_filt_we = 1'b1;
      cfg_filt_wdata = f;
      @(negedge clk);
      cfg_filt_we = 1'b0;
   endtask

   task automatic read_word(logic [AW-1:0] a, output logic [15:0] d);
      @(negedge clk);
      mem_addr = a;
      @(negedge clk);
      d = mem_rdata;
   endtask

   task automatic send_one(int ch, logic [3:0] rq, logic [23:0] orb, logic [11:0] bn, logic [7:0] sd);
      @(negedge clk);
      load_fields(ch, rq, orb, bn, sd);
      msg_valid = '0;
      msg_valid[ch] = 1'b1;
      @(negedge clk);
      msg_valid = '0;
      @(negedge clk);
   endtask

   task automatic check_record(string tag, logic [AW-1:0] base, int ch, logic [3:0] rq,
                               logic [23:0] orb, logic [11:0] bn, logic [7:0] sd);
      logic [15:0] w;
      read_word(base + 0, w); chk({tag, " word0"}, 32'(w), 32'({4'h0, rq, orb[23:16]}));
      read_word(base + 1, w); chk({tag, " word1"}, 32'(w), 32'(orb[15:0]));
      read_word(base + 2, w); chk({tag, " word2"}, 32'(w), 32'({4'h0, bn}));
      read_word(base + 3, w); chk({tag, " word3"}, 32'(w), 32'({sd, 8'(ch)}));
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] p0;
      logic [15:0]   w;
      int            k;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state
      chk("R3 reset wr_ptr", 32'(wr_ptr), 32'h0);
      chk("R5 reset filter", 32'(filt_q), 32'h0);
      chk("R9 reset rdata", 32'(mem_rdata), 32'h0);

      // Plain bus write and readback
      @(negedge clk);
      mem_addr = 12'hFF1; mem_we = 1'b1; mem_wdata = 16'h1234;
      @(negedge clk);
      mem_we = 1'b0;
      read_word(12'hFF1, w);
      chk("R9 bus readback", 32'(w), 32'h1234);
      chk("R3 bus write leaves ptr", 32'(wr_ptr), 32'h0);

      // Filter table
      for (int i = 0; i < NVEC; i++) begin
         logic [66:0] v;
         v = VEC[i];
         set_filter(v[16:1]);
         chk($sformatf("R5 filter load vec%0d", i), 32'(filt_q), 32'(v[16:1]));
         p0 = wr_ptr;
         send_one(int'(v[66:65]), v[64:61], v[60:37], v[36:25], v[24:17]);
         if (v[0]) begin
            chk($sformatf("R6 stored ptr vec%0d", i), 32'(wr_ptr), 32'(AW'(p0 + 4)));
            check_record($sformatf("R1 R2 vec%0d", i), p0, int'(v[66:65]),
                         v[64:61], v[60:37], v[36:25], v[24:17]);
         end else begin
            chk($sformatf("R6 filtered ptr vec%0d", i), 32'(wr_ptr), 32'(p0));
         end
      end

      // All channels in one cycle
      set_filter(16'h0000);
      p0 = wr_ptr;
      @(negedge clk);
      for (int c = 0; c < NCH; c++)
         load_fields(c, 4'(c + 1), 24'h0F0000 + 24'(c), 12'h100 + 12'(c), 8'hC0 + 8'(c));
      msg_valid = '1;
      @(negedge clk);
      msg_valid = '0;
      chk("R2 capture edge no write", 32'(wr_ptr), 32'(p0));
      for (int c = 0; c < NCH; c++) begin
         @(negedge clk);
         chk($sformatf("R7 one per cycle step%0d", c), 32'(wr_ptr), 32'(AW'(p0 + 4*(c + 1))));
      end
      for (int c = 0; c < NCH; c++)
         check_record($sformatf("R7 order ch%0d", c), AW'(p0 + 4*c), c, 4'(c + 1),
                      24'h0F0000 + 24'(c), 12'h100 + 12'(c), 8'hC0 + 8'(c));

      // Busy slot drops a second message
      p0 = wr_ptr;
      @(negedge clk);
      load_fields(0, 4'h8, 24'h111111, 12'h111, 8'hA0);
      load_fields(1, 4'h9, 24'h222222, 12'h222, 8'hA1);
      msg_valid = 4'b0011;
      @(negedge clk);
      load_fields(1, 4'hE, 24'h999999, 12'h999, 8'hEE);
      msg_valid = 4'b0010;
      @(negedge clk);
      msg_valid = '0;
      @(negedge clk);
      chk("R8 two records", 32'(wr_ptr), 32'(AW'(p0 + 8)));
      @(negedge clk);
      chk("R8 no third record", 32'(wr_ptr), 32'(AW'(p0 + 8)));
      check_record("R8 held kept", AW'(p0 + 4), 1, 4'h9, 24'h222222, 12'h222, 8'hA1);

      // Collision: record write beats bus write
      p0 = wr_ptr;
      @(negedge clk);
      load_fields(2, 4'h5, 24'h00BEEF, 12'h0AB, 8'h55);
      msg_valid = 4'b0100;
      @(negedge clk);
      msg_valid = '0;
      mem_addr = AW'(p0 + 1); mem_we = 1'b1; mem_wdata = 16'hDEAD;
      @(negedge clk);
      mem_we = 1'b0;
      read_word(AW'(p0 + 1), w);
      chk("R10 record wins collision", 32'(w), 32'hBEEF);

      // Fill to the top and wrap
      k = (4092 - int'(wr_ptr)) / 4;
      @(negedge clk);
      load_fields(0, 4'h1, 24'h000001, 12'h001, 8'h01);
      msg_valid = 4'b0001;
      repeat (k - 1) @(negedge clk);
      @(negedge clk);
      msg_valid = '0;
      @(negedge clk);
      chk("R3 ptr at last slot", 32'(wr_ptr), 32'd4092);
      send_one(1, 4'hC, 24'hC0FFEE, 12'hCAF, 8'hCC);
      chk("R4 ptr wraps", 32'(wr_ptr), 32'h0);
      check_record("R4 last slot", 12'd4092, 1, 4'hC, 24'hC0FFEE, 12'hCAF, 8'hCC);
      send_one(2, 4'hD, 24'hD00D00, 12'hD0D, 8'hDD);
      chk("R4 ptr after wrap", 32'(wr_ptr), 32'h4);
      check_record("R4 first slot", 12'd0, 2, 4'hD, 24'hD00D00, 12'hD0D, 8'hDD);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule